// File: doc/BRIEF.md
# Ethernet Receive Frame Status Tracker

This block sits beside the receive path of an Ethernet MAC and records what happened to the most recent frame. It watches a start-of-frame pulse, one strobe per received byte, and an end-of-frame pulse. The end-of-frame pulse carries the count of leftover dribble bits, the CRC verdict and the destination address class. From these it builds a seven-bit status word and a sixteen-bit byte count. Both hold until the next frame begins. The status word is also offered unchanged as a packet stamp, for the buffer logic to prepend to the stored frame.

The error bits depend on each other. A CRC error is reported only for frames that are not runts. An alignment error is reported only together with a CRC error. The runt threshold comes from a programmable slot-time setting. A live runt flag reports whether the frame being counted is still below the runt size. CRC computation, hash filtering, frame storage and register access are done elsewhere.

Top module: `rxf_status_tracker`

## Requirements
- R1: In the cycle after a start-of-frame, status bits 5 to 0 read zero. The byte count reads 1 if a byte strobe came with the start-of-frame and 0 otherwise. Bit 6 is not cleared.
- R2: Status bit 6 equals the monitor-mode input of the previous cycle, at all times outside reset.
- R3: At end-of-frame, bit 5 is set when the address class is 3 (broadcast) and bit 4 when it is 2 (multicast hash hit). Class 1 is unicast and class 0 is no match.
- R4: Bit 3 (missed) is set when the frame overflowed the buffer at any point from start to end. It is also set when the frame is clean, its address class is non-zero and monitor mode is on at end-of-frame.
- R5: Bit 2 (CRC error) is set when the frame is not a runt and either the CRC verdict was bad at end-of-frame or the MII receive-error input was high in any cycle from start to end of the frame.
- R6: Bit 1 (alignment error) is set exactly when bit 2 is set and the dribble-bit count at end-of-frame is non-zero.
- R7: Bit 0 (intact) is set when all of these hold: the CRC verdict is good, no MII receive error was seen, the frame is not a rejected runt, the address class is non-zero, monitor mode is off and there was no overflow. A clean frame is one that meets the first three.
- R8: The byte count rises by one for each byte strobe while a frame is active, including the start and end cycles. It stops at 0xFFFF.
- R9: The runt size is (slot setting + 1) × 4 bytes. A frame whose final byte count is below it is a runt. It is a rejected runt when accept-runts is off.
- R10: The runt flag is 1 exactly when accept-runts is off and the current byte count is below the runt size.
- R11: The packet stamp always equals the status word.
- R12: End-of-frame pulses and byte strobes outside an active frame change neither the status bits 5 to 0 nor the byte count.
- R13: A synchronous reset clears the status word, the byte count and any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_vld_i | input | 1 | One received byte this cycle |
| eof_i | input | 1 | End-of-frame pulse |
| dribble_i | input | 3 | Leftover bit count at end-of-frame |
| crc_ok_i | input | 1 | CRC verdict, sampled at end-of-frame |
| mii_rx_err_i | input | 1 | MII receive-error level |
| addr_class_i | input | 2 | Address class at end-of-frame (0 none, 1 unicast, 2 multicast, 3 broadcast) |
| overflow_i | input | 1 | Buffer overflow for the current frame |
| monitor_mode_i | input | 1 | Receiver in monitor mode |
| slot_time_i | input | 5 | Slot-time setting |
| accept_runts_i | input | 1 | Keep frames below the runt size |
| status_o | output | 7 | Status of the most recent frame |
| byte_count_o | output | 16 | Byte count of the current or last frame |
| runt_o | output | 1 | Live runt flag |
| stamp_o | output | 7 | Packet stamp |

## Verification
Status bits, the byte count and the stamp are registered. Each is due one clock edge after the cycle that carried the start-of-frame, byte strobe, end-of-frame or monitor-mode value that caused it. The runt flag is combinational from the registered count and the current slot and accept-runts inputs, so it is due in the same cycle as the count. The bench drives inputs on the falling edge and advances its behavioural model across exactly one rising edge. It compares every output at the next falling edge, which places each check in the cycle where the result is due.

// File: rtl/rxf_status_pkg.sv
package rxf_status_pkg;

  localparam int STAT_W      = 7;
  localparam int DEF_SLOT_W  = 5;
  localparam int DEF_CNT_W   = 16;
  localparam int DRIB_W      = 3;

  typedef enum logic [1:0] {
    ADDR_NONE  = 2'd0,
    ADDR_UNI   = 2'd1,
    ADDR_MULTI = 2'd2,
    ADDR_BCAST = 2'd3
  } addr_class_e;

  localparam int BIT_INTACT = 0;
  localparam int BIT_ALIGN  = 1;
  localparam int BIT_CRC    = 2;
  localparam int BIT_MISS   = 3;
  localparam int BIT_MCAST  = 4;
  localparam int BIT_BCAST  = 5;
  localparam int BIT_MON    = 6;

  // End-of-frame verdict for the six frame bits (bit 6 is handled apart).
  function automatic logic [5:0] frame_verdict(
    input logic        runt,
    input logic        accept_runts,
    input logic        crc_ok,
    input logic        mii_err_seen,
    input logic        ovf_seen,
    input logic        dribble_nz,
    input logic        monitor,
    input addr_class_e cls
  );
    logic [5:0] v;
    logic       bad_check;
    logic       runt_drop;
    logic       clean;
    logic       hit;
    bad_check = !crc_ok || mii_err_seen;
    runt_drop = runt && !accept_runts;
    clean     = !bad_check && !runt_drop;
    hit       = (cls != ADDR_NONE);
    v = '0;
    v[BIT_BCAST]  = (cls == ADDR_BCAST);
    v[BIT_MCAST]  = (cls == ADDR_MULTI);
    v[BIT_CRC]    = bad_check && !runt;
    v[BIT_ALIGN]  = bad_check && !runt && dribble_nz;
    v[BIT_MISS]   = ovf_seen || (clean && hit && monitor);
    v[BIT_INTACT] = clean && hit && !monitor && !ovf_seen;
    return v;
  endfunction

endpackage

// File: rtl/rxf_frame_tracker.sv
module rxf_frame_tracker (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic eof_i,
  input  logic mii_rx_err_i,
  input  logic overflow_i,
  output logic active_o,
  output logic count_en_o,
  output logic eof_take_o,
  output logic mii_seen_o,
  output logic ovf_seen_o
);

  logic active_q;
  logic mii_q;
  logic ovf_q;

  // start wins over end in the same cycle; end only counts inside a frame
  assign eof_take_o = eof_i && active_q && !sof_i;
  assign count_en_o = sof_i || active_q;
  assign active_o   = active_q;
  assign mii_seen_o = mii_q || mii_rx_err_i;
  assign ovf_seen_o = ovf_q || overflow_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mii_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else if (sof_i) begin
      active_q <= 1'b1;
      mii_q    <= mii_rx_err_i;
      ovf_q    <= overflow_i;
    end else if (active_q) begin
      mii_q    <= mii_q || mii_rx_err_i;
      ovf_q    <= ovf_q || overflow_i;
      if (eof_i) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rxf_byte_counter.sv
module rxf_byte_counter #(
  parameter int CNT_W    = 16,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic             count_en_i,
  input  logic             byte_vld_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             room;

  generate
    if (SATURATE) begin : g_sat
      assign room = ~&cnt_q;
    end else begin : g_wrap
      assign room = 1'b1;
    end
  endgenerate

  function automatic logic [CNT_W-1:0] advance(
    input logic [CNT_W-1:0] cur,
    input logic             start,
    input logic             en,
    input logic             strobe,
    input logic             can_grow
  );
    if (start)
      return {{(CNT_W-1){1'b0}}, strobe};
    if (en && strobe && can_grow)
      return cur + {{(CNT_W-1){1'b0}}, 1'b1};
    return cur;
  endfunction

  assign count_next_o = advance(cnt_q, sof_i, count_en_i, byte_vld_i, room);
  assign count_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= count_next_o;
  end

endmodule

// File: rtl/rxf_runt_gauge.sv
module rxf_runt_gauge #(
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic [SLOT_W-1:0] slot_time_i,
  input  logic              accept_runts_i,
  input  logic [CNT_W-1:0]  live_count_i,
  input  logic [CNT_W-1:0]  final_count_i,
  output logic              runt_live_o,
  output logic              runt_final_o
);

  localparam int SIZE_W = SLOT_W + 3;
  localparam int CMP_W  = (CNT_W > SIZE_W) ? CNT_W : SIZE_W;

  // slot in bits = (setting+1)*32, so bytes = (setting+1)*4
  function automatic logic [SIZE_W-1:0] runt_bytes(input logic [SLOT_W-1:0] s);
    logic [SIZE_W-1:0] ext;
    ext = {3'b000, s};
    return (ext + {{(SIZE_W-1){1'b0}}, 1'b1}) << 2;
  endfunction

  logic [CMP_W-1:0] size_w;
  logic [CMP_W-1:0] live_w;
  logic [CMP_W-1:0] final_w;

  assign size_w  = CMP_W'(runt_bytes(slot_time_i));
  assign live_w  = CMP_W'(live_count_i);
  assign final_w = CMP_W'(final_count_i);

  assign runt_final_o = (final_w < size_w);
  assign runt_live_o  = !accept_runts_i && (live_w < size_w);

endmodule

// File: rtl/rxf_status_reg.sv
module rxf_status_reg
  import rxf_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              eof_take_i,
  input  logic              monitor_i,
  input  logic [5:0]        verdict_i,
  output logic [STAT_W-1:0] status_o
);

  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q[BIT_MON] <= monitor_i;
      if (sof_i)
        stat_q[5:0] <= '0;
      else if (eof_take_i)
        stat_q[5:0] <= verdict_i;
    end
  end

  assign status_o = stat_q;

endmodule

// File: rtl/rxf_status_tracker.sv
module rxf_status_tracker
  import rxf_status_pkg::*;
#(
  parameter int SLOT_W   = DEF_SLOT_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter bit SATURATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic              eof_i,
  input  logic [2:0]        dribble_i,
  input  logic              crc_ok_i,
  input  logic              mii_rx_err_i,
  input  logic [1:0]        addr_class_i,
  input  logic              overflow_i,
  input  logic              monitor_mode_i,
  input  logic [SLOT_W-1:0] slot_time_i,
  input  logic              accept_runts_i,
  output logic [6:0]        status_o,
  output logic [CNT_W-1:0]  byte_count_o,
  output logic              runt_o,
  output logic [6:0]        stamp_o
);

  logic             frame_active_w;
  logic             count_en_w;
  logic             eof_take_w;
  logic             mii_seen_w;
  logic             ovf_seen_w;
  logic [CNT_W-1:0] count_next_w;
  logic             runt_final_w;
  logic [5:0]       verdict_w;

  rxf_frame_tracker u_frame (
    .clk          (clk),
    .rst          (rst),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .mii_rx_err_i (mii_rx_err_i),
    .overflow_i   (overflow_i),
    .active_o     (frame_active_w),
    .count_en_o   (count_en_w),
    .eof_take_o   (eof_take_w),
    .mii_seen_o   (mii_seen_w),
    .ovf_seen_o   (ovf_seen_w)
  );

  rxf_byte_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_count (
    .clk          (clk),
    .rst          (rst),
    .sof_i        (sof_i),
    .count_en_i   (count_en_w),
    .byte_vld_i   (byte_vld_i),
    .count_o      (byte_count_o),
    .count_next_o (count_next_w)
  );

  rxf_runt_gauge #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_runt (
    .slot_time_i    (slot_time_i),
    .accept_runts_i (accept_runts_i),
    .live_count_i   (byte_count_o),
    .final_count_i  (count_next_w),
    .runt_live_o    (runt_o),
    .runt_final_o   (runt_final_w)
  );

  assign verdict_w = frame_verdict(runt_final_w, accept_runts_i, crc_ok_i,
                                   mii_seen_w, ovf_seen_w, |dribble_i,
                                   monitor_mode_i, addr_class_e'(addr_class_i));

  rxf_status_reg u_stat (
    .clk        (clk),
    .rst        (rst),
    .sof_i      (sof_i),
    .eof_take_i (eof_take_w),
    .monitor_i  (monitor_mode_i),
    .verdict_i  (verdict_w),
    .status_o   (status_o)
  );

  assign stamp_o = status_o;

endmodule

// File: rtl/rxf_status_checker.sv
module rxf_status_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sof_i,
  input logic             byte_vld_i,
  input logic             monitor_mode_i,
  input logic             accept_runts_i,
  input logic             frame_active,
  input logic [6:0]       status_o,
  input logic [CNT_W-1:0] byte_count_o,
  input logic             runt_o
);

  assert_sof_clears_R1: assert property (@(posedge clk) disable iff (rst)
    sof_i |=> (status_o[5:0] == 6'd0) &&
              (byte_count_o == CNT_W'($past(byte_vld_i))));

  assert_monitor_follow_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_o[6] == $past(monitor_mode_i));

  assert_align_needs_crc_R6: assert property (@(posedge clk) disable iff (rst)
    status_o[1] |-> status_o[2]);

  assert_intact_excl_R7: assert property (@(posedge clk) disable iff (rst)
    status_o[0] |-> !status_o[2] && !status_o[3]);

  assert_runt_accept_R10: assert property (@(posedge clk) disable iff (rst)
    accept_runts_i |-> !runt_o);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!frame_active && !sof_i) |=> $stable(byte_count_o) && $stable(status_o[5:0]));

endmodule

bind rxf_status_tracker rxf_status_checker #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .sof_i          (sof_i),
  .byte_vld_i     (byte_vld_i),
  .monitor_mode_i (monitor_mode_i),
  .accept_runts_i (accept_runts_i),
  .frame_active   (frame_active_w),
  .status_o       (status_o),
  .byte_count_o   (byte_count_o),
  .runt_o         (runt_o)
);

// File: tb/tb_rxf_status_tracker.sv
`timescale 1ns/1ps
module tb_rxf_status_tracker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof_i = 0, byte_vld_i = 0, eof_i = 0, crc_ok_i = 1;
  logic [2:0]  dribble_i = 0;
  logic        mii_rx_err_i = 0, overflow_i = 0, monitor_mode_i = 0;
  logic [1:0]  addr_class_i = 0;
  logic [4:0]  slot_time_i = 5'h0F;
  logic        accept_runts_i = 0;
  logic [6:0]  status_o, stamp_o;
  logic [15:0] byte_count_o;
  logic        runt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_act = 0, m_mii = 0, m_ovf = 0;
  bit [6:0] m_st = 0;

  always #10 clk = ~clk;

  rxf_status_tracker dut (
    .clk(clk), .rst(rst), .sof_i(sof_i), .byte_vld_i(byte_vld_i), .eof_i(eof_i),
    .dribble_i(dribble_i), .crc_ok_i(crc_ok_i), .mii_rx_err_i(mii_rx_err_i),
    .addr_class_i(addr_class_i), .overflow_i(overflow_i),
    .monitor_mode_i(monitor_mode_i), .slot_time_i(slot_time_i),
    .accept_runts_i(accept_runts_i), .status_o(status_o),
    .byte_count_o(byte_count_o), .runt_o(runt_o), .stamp_o(stamp_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int runt_bytes();
    return (int'(slot_time_i) + 1) * 32 / 8;
  endfunction

  task automatic compare_all();
    chk("R2 monitor bit",   int'(status_o[6]), int'(m_st[6]));
    chk("R3 broadcast bit", int'(status_o[5]), int'(m_st[5]));
    chk("R3 multicast bit", int'(status_o[4]), int'(m_st[4]));
    chk("R4 missed bit",    int'(status_o[3]), int'(m_st[3]));
    chk("R5 crc bit",       int'(status_o[2]), int'(m_st[2]));
    chk("R6 align bit",     int'(status_o[1]), int'(m_st[1]));
    chk("R7 intact bit",    int'(status_o[0]), int'(m_st[0]));
    chk("R8 byte count",    int'(byte_count_o), m_cnt);
    chk("R10 runt flag",    int'(runt_o), int'(!accept_runts_i && m_cnt < runt_bytes()));
    chk("R11 stamp",        int'(stamp_o), int'(status_o));
  endtask

  // advance one clock: model consumes current inputs, then outputs compared
  task automatic tick();
    bit [6:0] ns = m_st;
    int  nc = m_cnt;
    bit  na = m_act, nm = m_mii, no = m_ovf;
    if (rst) begin
      ns = 0; nc = 0; na = 0; nm = 0; no = 0;
    end else begin
      ns[6] = monitor_mode_i;
      if (sof_i) begin
        na = 1; nc = byte_vld_i ? 1 : 0; nm = mii_rx_err_i; no = overflow_i;
        ns[5:0] = 0;
      end else if (m_act) begin
        if (byte_vld_i && nc < 65535) nc = nc + 1;
        nm = m_mii | mii_rx_err_i;
        no = m_ovf | overflow_i;
        if (eof_i) begin
          bit runt  = nc < runt_bytes();
          bit bad   = !crc_ok_i || nm;
          bit keep  = !bad && !(runt && !accept_runts_i);
          bit hit   = addr_class_i != 2'd0;
          ns[5] = addr_class_i == 2'd3;
          ns[4] = addr_class_i == 2'd2;
          ns[2] = bad && !runt;
          ns[1] = ns[2] && dribble_i != 0;
          ns[3] = no || (keep && hit && monitor_mode_i);
          ns[0] = keep && hit && !monitor_mode_i && !no;
          na = 0;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_st = ns; m_cnt = nc; m_act = na; m_mii = nm; m_ovf = no;
    compare_all();
  endtask

  task automatic idle_inputs();
    sof_i = 0; byte_vld_i = 0; eof_i = 0; dribble_i = 0;
    mii_rx_err_i = 0; overflow_i = 0;
  endtask

  task automatic frame(input int n, input bit crc, input int mii_at,
                       input int drib, input int cls, input bit ovf, input bit gaps);
    for (int i = 0; i < n; i++) begin
      sof_i        = (i == 0);
      eof_i        = (i == n - 1);
      byte_vld_i   = !(gaps && (i % 5 == 3) && i != n - 1);
      mii_rx_err_i = (i == mii_at);
      overflow_i   = ovf && (i == n / 2);
      crc_ok_i     = crc;
      dribble_i    = (i == n - 1) ? 3'(drib) : 3'd0;
      addr_class_i = 2'(cls);
      tick();
      if (i == 0) begin
        chk("R1 status cleared after start", int'(status_o[5:0]), 0);
        chk("R1 count after start", int'(byte_count_o), 1);
      end
    end
    idle_inputs();
    tick();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; tick(); tick();
    rst = 0; tick();
    chk("R13 reset status", int'(status_o), 0);
    chk("R13 reset count", int'(byte_count_o), 0);

    frame(64, 1, -1, 0, 1, 0, 0);
    chk("R7 good unicast stamp", int'(stamp_o), 'h01);
    frame(100, 1, -1, 0, 3, 0, 1);
    chk("R3 broadcast stamp", int'(stamp_o), 'h21);
    frame(80, 0, -1, 3, 2, 0, 0);
    chk("R6 misaligned crc multicast", int'(stamp_o), 'h16);
    frame(80, 0, -1, 0, 1, 0, 0);
    chk("R5 crc only", int'(stamp_o), 'h04);
    frame(70, 1, 30, 0, 1, 0, 0);
    chk("R5 mii error", int'(stamp_o), 'h04);
    frame(20, 0, -1, 5, 1, 0, 0);
    chk("R9 runt crc suppressed", int'(stamp_o), 'h00);
    frame(63, 1, -1, 0, 1, 0, 0);
    chk("R9 63 bytes is runt", int'(stamp_o), 'h00);
    accept_runts_i = 1;
    frame(20, 1, -1, 0, 1, 0, 0);
    chk("R9 accepted runt intact", int'(stamp_o), 'h01);
    accept_runts_i = 0;
    monitor_mode_i = 1; tick();
    frame(64, 1, -1, 0, 3, 0, 0);
    chk("R4 monitor missed", int'(stamp_o), 'h68);
    monitor_mode_i = 0; tick();
    frame(90, 1, -1, 0, 1, 1, 0);
    chk("R4 overflow missed", int'(stamp_o), 'h08);
    frame(90, 1, -1, 0, 0, 0, 0);
    chk("R7 no address match", int'(stamp_o), 'h00);
    slot_time_i = 5'h01; tick();
    frame(10, 0, -1, 1, 1, 0, 0);
    chk("R9 small slot not runt", int'(stamp_o), 'h06);
    slot_time_i = 5'h1F; tick();
    frame(100, 0, -1, 1, 1, 0, 0);
    chk("R9 large slot runt", int'(stamp_o), 'h00);
    slot_time_i = 5'h0F; tick();
    frame(64, 1, -1, 0, 2, 0, 0);

    // stray end and strobes outside a frame
    byte_vld_i = 1; eof_i = 1; crc_ok_i = 0; addr_class_i = 3; tick(); tick();
    idle_inputs(); tick();
    chk("R12 stray count", int'(byte_count_o), 64);
    chk("R12 stray status", int'(status_o[5:0]), 'h11);

    // reset mid-frame
    sof_i = 1; byte_vld_i = 1; tick();
    sof_i = 0; tick(); tick();
    rst = 1; tick();
    rst = 0; idle_inputs(); tick();
    chk("R13 reset mid-frame count", int'(byte_count_o), 0);
    eof_i = 1; tick(); idle_inputs(); tick();
    chk("R13 no frame after reset", int'(status_o[5:0]), 0);

    // saturation
    crc_ok_i = 1;
    frame(65540, 1, -1, 0, 1, 0, 0);
    chk("R8 saturated count", int'(byte_count_o), 65535);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule